// File: doc/BRIEF.md
# Operand Addressing-Mode Resolver

This block takes a 24-bit operand specifier and produces the 20-bit value that the operand stands for. The top four bits of the specifier are a mode nibble and the low twenty bits are a field. Bit 3 of the nibble marks a register operand, and then the field names a register. Otherwise the field is a literal or a memory address. Depending on the mode, the resolver reads the register file and issues up to two dependent reads on a synchronous memory port. It returns the value, the effective address of the last read when there was one, and an error flag for specifiers it does not accept.

Requests come in on a valid/ready channel. `req_ready` is high only when the block is idle and no response is waiting. One request is in flight at a time. Responses go out on a valid/ready channel. When a response is presented it stays on the outputs, unchanged, until it is taken with `rsp_ready`. No new request is accepted while a response waits.

The register file port is combinational: `reg_id` is driven from the specifier and `reg_rdata` is used in the same cycle. On the memory port, `mem_addr` is sampled with `mem_rd_en` at a clock edge, and `mem_rdata` is valid in the cycle after that edge.

Top module: `opr_resolver`

## Requirements
- R1: Mode 0x0 (immediate) returns the field as the value. The response is valid one cycle after acceptance, with no memory read, `rsp_addr_valid` low and `rsp_err` low.
- R2: Mode 0x1 (direct) reads memory once at the field address. It returns the word read as the value and the field as the effective address, with `rsp_addr_valid` high, two cycles after acceptance.
- R3: Mode 0x2 (pointer) reads the word at the field address, uses that word as a second address and reads again. It returns the second word as the value and the second address as the effective address, three cycles after acceptance, after exactly two reads.
- R4: Mode 0x3 (stack index) reads register id 0 (the stack pointer) and subtracts the field from it modulo 2^20. It then resolves the difference as in R3, three cycles after acceptance.
- R5: Mode 0x8 returns the contents of the register named by field bits 3:0, one cycle after acceptance, with no memory read. The valid ids are 0 to 4 and 8 to 12, and field bits 19:4 must be zero.
- R6: Mode 0x9 reads memory once at the contents of the named register. It returns that word as the value and the register contents as the effective address, two cycles after acceptance.
- R7: Mode 0xA performs two chained reads starting from the contents of the named register. It returns the second word as the value and the second address as the effective address, three cycles after acceptance.
- R8: Modes 0x4 to 0x7 and 0xB to 0xF, and modes 0x8 to 0xA with an invalid register id, raise `rsp_err`. Such a request makes no memory read and returns value 0 with `rsp_addr_valid` low, one cycle after acceptance.
- R9: While `rsp_valid` is high and `rsp_ready` is low, all response outputs hold their values. `req_ready` stays low while a response is pending.
- R10: After reset `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Specifier offered |
| req_ready | output | 1 | Block idle with no pending response |
| req_spec | input | 24 | Mode nibble in bits 23:20, field in bits 19:0 |
| rsp_valid | output | 1 | Response presented |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_value | output | 20 | Resolved operand value |
| rsp_addr | output | 20 | Effective address of the last read |
| rsp_addr_valid | output | 1 | The response carries an effective address |
| rsp_err | output | 1 | Specifier not supported |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 20 | Memory read address |
| mem_rdata | input | 20 | Read data, one cycle after the strobe |
| reg_id | output | 4 | Register file read id |
| reg_rdata | input | 20 | Register file read data, same cycle |

## Verification
Latency is counted from the accepting edge, with that edge counted as one. Immediate, register-value and rejected specifiers are due at that edge. Direct and register-indirect specifiers are due one edge later. Pointer, stack-index and double-register specifiers are due two edges later. The driver records the cycle count at the accepting edge. The monitor samples on falling edges and compares the cycle of the first `rsp_valid` against the expected latency. It also counts the read strobes seen since the previous response. During stalls it checks every held cycle against the values captured when the response first appeared.

// File: rtl/opr_pkg.sv
package opr_pkg;

  // Where the first address (or the direct value) comes from.
  typedef enum logic [1:0] {
    BASE_FIELD = 2'd0,
    BASE_REG   = 2'd1,
    BASE_STACK = 2'd2
  } base_sel_e;

  // Decoded request: error flag, number of chained reads, base selection.
  typedef struct packed {
    logic      err;
    logic [1:0] n_reads;
    base_sel_e base;
  } opr_plan_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RD1  = 2'd1,
    SQ_RD2  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
#(
  parameter int unsigned                   FIELD_W    = 20,
  parameter int unsigned                   REG_ID_W   = 4,
  parameter logic [(2**REG_ID_W)-1:0]      REG_ID_MAP = 16'h1F1F
) (
  input  logic [3:0]         mode,
  input  logic [FIELD_W-1:0] field,
  output opr_plan_t          plan
);

  logic                reg_flag;
  logic [2:0]          sub;
  logic [REG_ID_W-1:0] id;
  logic                id_ok;

  assign reg_flag = mode[3];
  assign sub      = mode[2:0];
  assign id       = field[REG_ID_W-1:0];
  assign id_ok    = (field[FIELD_W-1:REG_ID_W] == '0) && REG_ID_MAP[id];

  always_comb begin
    plan.err     = 1'b0;
    plan.n_reads = 2'd0;
    plan.base    = BASE_FIELD;
    if (sub[2]) begin
      plan.err = 1'b1;
    end else if (reg_flag) begin
      plan.base = BASE_REG;
      if (sub == 3'd3 || !id_ok) plan.err = 1'b1;
      else                       plan.n_reads = sub[1:0];
    end else if (sub == 3'd3) begin
      plan.base    = BASE_STACK;
      plan.n_reads = 2'd2;
    end else begin
      plan.n_reads = sub[1:0];
    end
  end

endmodule

// File: rtl/opr_addr_gen.sv
module opr_addr_gen
  import opr_pkg::*;
#(
  parameter int unsigned          W        = 20,
  parameter int unsigned          REG_ID_W = 4,
  parameter logic [REG_ID_W-1:0]  SP_ID    = '0
) (
  input  base_sel_e           base,
  input  logic                err,
  input  logic [W-1:0]        field,
  input  logic [W-1:0]        reg_data,
  output logic [REG_ID_W-1:0] reg_id,
  output logic [W-1:0]        first_addr,
  output logic [W-1:0]        direct_value
);

  // Stack-index mode always reads the stack pointer.
  assign reg_id = (base == BASE_STACK) ? SP_ID : field[REG_ID_W-1:0];

  always_comb begin
    unique case (base)
      BASE_REG:   first_addr = reg_data;
      BASE_STACK: first_addr = reg_data - field;   // wraps modulo 2^W
      default:    first_addr = field;
    endcase
  end

  always_comb begin
    if (err)                   direct_value = '0;
    else if (base == BASE_REG) direct_value = reg_data;
    else                       direct_value = field;
  end

endmodule

// File: rtl/opr_seq.sv
module opr_seq
  import opr_pkg::*;
#(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [1:0]   n_reads,
  input  logic         err,
  input  logic [W-1:0] first_addr,
  input  logic [W-1:0] direct_value,
  output logic         mem_rd_en,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_value,
  output logic [W-1:0] rsp_addr,
  output logic         rsp_addr_valid,
  output logic         rsp_err
);

  seq_state_e   state_q;
  logic         chain_q;
  logic [W-1:0] addr_q;
  logic         fire;

  assign req_ready = (state_q == SQ_IDLE) && !rsp_valid;
  assign fire      = req_valid && req_ready;

  // First read goes out in the accepting cycle; the second is chained off
  // the returning data in the following cycle.
  assign mem_rd_en = (fire && n_reads != 2'd0) || (state_q == SQ_RD1 && chain_q);
  assign mem_addr  = (state_q == SQ_IDLE) ? first_addr : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= SQ_IDLE;
      chain_q        <= 1'b0;
      addr_q         <= '0;
      rsp_valid      <= 1'b0;
      rsp_value      <= '0;
      rsp_addr       <= '0;
      rsp_addr_valid <= 1'b0;
      rsp_err        <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (fire) begin
            if (n_reads == 2'd0) begin
              rsp_valid      <= 1'b1;
              rsp_value      <= direct_value;
              rsp_addr       <= '0;
              rsp_addr_valid <= 1'b0;
              rsp_err        <= err;
            end else begin
              state_q <= SQ_RD1;
              chain_q <= (n_reads == 2'd2);
              addr_q  <= first_addr;
            end
          end
        end
        SQ_RD1: begin
          if (chain_q) begin
            state_q <= SQ_RD2;
            addr_q  <= mem_rdata;
          end else begin
            state_q        <= SQ_IDLE;
            rsp_valid      <= 1'b1;
            rsp_value      <= mem_rdata;
            rsp_addr       <= addr_q;
            rsp_addr_valid <= 1'b1;
            rsp_err        <= 1'b0;
          end
        end
        default: begin
          state_q        <= SQ_IDLE;
          rsp_valid      <= 1'b1;
          rsp_value      <= mem_rdata;
          rsp_addr       <= addr_q;
          rsp_addr_valid <= 1'b1;
          rsp_err        <= 1'b0;
        end
      endcase
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_value) &&
      $stable(rsp_addr) && $stable(rsp_addr_valid) && $stable(rsp_err));

  assert_no_accept_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_err_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_value == '0 && !rsp_addr_valid);

  assert_chain_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SQ_RD2 |=> rsp_valid && rsp_addr_valid);

  assert_quiet_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_rd_en);

endmodule

// File: rtl/opr_resolver.sv
module opr_resolver
  import opr_pkg::*;
#(
  parameter int unsigned              W          = 20,
  parameter int unsigned              REG_ID_W   = 4,
  parameter logic [(2**REG_ID_W)-1:0] REG_ID_MAP = 16'h1F1F,
  parameter logic [REG_ID_W-1:0]      SP_ID      = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [W+3:0]        req_spec,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [W-1:0]        rsp_value,
  output logic [W-1:0]        rsp_addr,
  output logic                rsp_addr_valid,
  output logic                rsp_err,
  output logic                mem_rd_en,
  output logic [W-1:0]        mem_addr,
  input  logic [W-1:0]        mem_rdata,
  output logic [REG_ID_W-1:0] reg_id,
  input  logic [W-1:0]        reg_rdata
);

  localparam int unsigned SPEC_W = W + 4;

  logic [3:0]   mode;
  logic [W-1:0] field;
  opr_plan_t    plan;
  logic [W-1:0] first_addr;
  logic [W-1:0] direct_value;

  assign mode  = req_spec[SPEC_W-1:W];
  assign field = req_spec[W-1:0];

  opr_decode #(
    .FIELD_W   (W),
    .REG_ID_W  (REG_ID_W),
    .REG_ID_MAP(REG_ID_MAP)
  ) u_decode (
    .mode (mode),
    .field(field),
    .plan (plan)
  );

  opr_addr_gen #(
    .W       (W),
    .REG_ID_W(REG_ID_W),
    .SP_ID   (SP_ID)
  ) u_addr_gen (
    .base        (plan.base),
    .err         (plan.err),
    .field       (field),
    .reg_data    (reg_rdata),
    .reg_id      (reg_id),
    .first_addr  (first_addr),
    .direct_value(direct_value)
  );

  opr_seq #(
    .W(W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .n_reads       (plan.n_reads),
    .err           (plan.err),
    .first_addr    (first_addr),
    .direct_value  (direct_value),
    .mem_rd_en     (mem_rd_en),
    .mem_addr      (mem_addr),
    .mem_rdata     (mem_rdata),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_value     (rsp_value),
    .rsp_addr      (rsp_addr),
    .rsp_addr_valid(rsp_addr_valid),
    .rsp_err       (rsp_err)
  );

  assert_err_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (mode[2] || mode == 4'hB) |-> !mem_rd_en);

  assert_imm_no_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (mode == 4'h0 || mode == 4'h8) |-> !mem_rd_en);

  assert_stack_uses_sp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && mode == 4'h3 |-> reg_id == SP_ID && mem_rd_en);

endmodule

// File: tb/test_opr_resolver.sv
module test_opr_resolver;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_spec;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [19:0] rsp_value, rsp_addr;
  logic        rsp_addr_valid, rsp_err;
  logic        mem_rd_en;
  logic [19:0] mem_addr;
  logic [19:0] mem_rdata;
  logic [3:0]  reg_id;
  logic [19:0] reg_rdata;
  logic [19:0] regs [16];

  always #4 clk = ~clk;   // 125 MHz

  opr_resolver i_opr_resolver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_spec(req_spec), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_value(rsp_value), .rsp_addr(rsp_addr), .rsp_addr_valid(rsp_addr_valid),
    .rsp_err(rsp_err), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .reg_id(reg_id), .reg_rdata(reg_rdata)
  );

  function automatic logic [19:0] memf(input logic [19:0] a);
    logic [19:0] m;
    m = a * 20'd7;
    return (m + 20'h1357B) ^ {a[9:0], a[19:10]};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= memf(mem_addr);
  assign reg_rdata = regs[reg_id];

  typedef struct {
    logic [19:0] value;
    logic [19:0] addr;
    logic        av;
    logic        err;
    int          lat;
    int          nrd;
    int          stall;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   acc_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [23:0] spec, input string tag, input int stall);
    exp_t e;
    logic [3:0]  m;
    logic [19:0] f, a0;
    logic        ok;
    m = spec[23:20];
    f = spec[19:0];
    ok = (f[19:4] == 16'h0) && (f[3:0] <= 4'd4 || (f[3:0] >= 4'd8 && f[3:0] <= 4'd12));
    e.value = '0; e.addr = '0; e.av = 1'b0; e.err = 1'b0;
    e.lat = 1; e.nrd = 0; e.stall = stall; e.tag = tag;
    case (m)
      4'h0: e.value = f;
      4'h1: begin e.addr = f; e.value = memf(f); e.av = 1; e.lat = 2; e.nrd = 1; end
      4'h2: begin e.addr = memf(f); e.value = memf(e.addr); e.av = 1; e.lat = 3; e.nrd = 2; end
      4'h3: begin
        a0 = regs[0] - f;
        e.addr = memf(a0); e.value = memf(e.addr); e.av = 1; e.lat = 3; e.nrd = 2;
      end
      4'h8: if (ok) e.value = regs[f[3:0]]; else e.err = 1;
      4'h9: if (ok) begin
        e.addr = regs[f[3:0]]; e.value = memf(e.addr); e.av = 1; e.lat = 2; e.nrd = 1;
      end else e.err = 1;
      4'hA: if (ok) begin
        e.addr = memf(regs[f[3:0]]); e.value = memf(e.addr); e.av = 1; e.lat = 3; e.nrd = 2;
      end else e.err = 1;
      default: e.err = 1;
    endcase
    return e;
  endfunction

  task automatic send(input logic [23:0] spec, input string tag, input int stall);
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    exp_q.push_back(predict(spec, tag, stall));
    req_valid = 1'b1;
    req_spec  = spec;
    @(posedge clk); #1;
    acc_q.push_back(cyc);
    req_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    exp_t        e;
    int          acc, hold, rd_cnt;
    bit          seen;
    logic [19:0] h_val, h_addr;
    logic        h_av, h_err;
    hold = 0; rd_cnt = 0; seen = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (mem_rd_en) rd_cnt++;
        if (rsp_valid) begin
          if (!seen) begin
            if (exp_q.size() == 0 || acc_q.size() == 0) begin
              chk("R1", "unexpected response", 1, 0);
            end else begin
              e   = exp_q.pop_front();
              acc = acc_q.pop_front();
              chk(e.tag, "value", rsp_value, e.value);
              chk(e.tag, "addr_valid", rsp_addr_valid, e.av);
              if (e.av) chk(e.tag, "addr", rsp_addr, e.addr);
              chk(e.tag, "err", rsp_err, e.err);
              chk(e.tag, "latency", cyc - acc + 1, e.lat);
              chk(e.tag, "reads", rd_cnt, e.nrd);
              hold = e.stall;
            end
            rd_cnt = 0;
            seen = 1;
            h_val = rsp_value; h_addr = rsp_addr; h_av = rsp_addr_valid; h_err = rsp_err;
          end else begin
            chk("R9", "held value", rsp_value, h_val);
            chk("R9", "held addr", {rsp_addr, rsp_addr_valid, rsp_err}, {h_addr, h_av, h_err});
          end
          chk("R9", "req_ready while pending", req_ready, 0);
          rsp_ready = (hold == 0);
          if (hold > 0) hold--;
        end else begin
          seen = 0;
          rsp_ready = 1'b1;
        end
      end
    end
  end

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    regs[0]  = 20'h00010;  regs[1]  = 20'h0F0F0; regs[2]  = 20'h80000;
    regs[3]  = 20'h00321;  regs[4]  = 20'h4A5B6;
    for (int i = 5; i < 8; i++) regs[i] = 20'h0DEAD + i;
    regs[8]  = 20'h11111;  regs[9]  = 20'h22222; regs[10] = 20'h33333;
    regs[11] = 20'h44444;  regs[12] = 20'hFFFFF;
    for (int i = 13; i < 16; i++) regs[i] = 20'h0BEEF + i;
    rst_n = 1'b0; req_valid = 1'b0; req_spec = '0; rsp_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "req_ready after reset", req_ready, 1);
    chk("R10", "rsp_valid after reset", rsp_valid, 0);

    send(24'h0ABCDE, "R1", 0);
    send(24'h000000, "R1", 0);
    send(24'h112345, "R2", 0);
    send(24'h1FFFFF, "R2", 0);
    send(24'h200777, "R3", 0);
    send(24'h3FFFF0, "R3", 0);
    send(24'h300004, "R4", 0);
    send(24'h300020, "R4", 0);   // wraps below zero
    send(24'h300010, "R4", 0);
    send(24'h800000, "R5", 0);
    send(24'h800003, "R5", 0);
    send(24'h80000C, "R5", 0);
    send(24'h900004, "R6", 0);
    send(24'h900001, "R6", 0);
    send(24'hA00003, "R7", 0);
    send(24'hA00008, "R7", 0);
    send(24'h400123, "R8", 0);
    send(24'h7FFFFF, "R8", 0);
    send(24'hB00001, "R8", 0);
    send(24'hF00002, "R8", 0);
    send(24'h800005, "R8", 0);
    send(24'h90000D, "R8", 0);
    send(24'h810003, "R8", 0);
    send(24'hA00007, "R8", 0);
    send(24'h200777, "R9", 3);
    send(24'h0ABCDE, "R9", 2);
    send(24'h800004, "R9", 1);
    send(24'h500000, "R9", 4);

    while (exp_q.size() != 0 || rsp_valid) @(posedge clk);
    repeat (3) @(posedge clk);
    report();
  end

endmodule